// File: doc/BRIEF.md
# Register-Exchange Viterbi Decoder (rate 1/3, four states)

This block recovers a bit stream from a hard-decision channel that carries a rate-1/3, constraint-length-3 convolutional code. The generators are 5, 7 and 7 in octal. Each clock with `in_valid` high it takes one 3-bit received symbol. It forms Hamming branch metrics and runs add-compare-select over the four trellis states. The chosen decisions drive a register-exchange survivor array: every state carries its own decoded-bit history, which is copied from the winning predecessor and extended by one bit on every accepted symbol. No trace-back memory exists.

Once `DEPTH` symbols have been accepted, every further accepted symbol releases one decoded bit on `out_bit`, with `out_valid` pulsing for one cycle. The bit is the oldest entry of the history belonging to the state with the best metric. When `in_valid` is low the decoder holds all of its state. A small encoder for the same code is part of the project for producing stimulus.

A two-state control machine sequences the output. `ST_FILL` counts accepted symbols while the histories are still shorter than `DEPTH`. The transition FILL→RUN fires on the edge that accepts the `DEPTH`-th symbol. `ST_RUN` then holds until reset, and in that state every accepted symbol produces an output.

Top module: `rexvit_decoder`

## Requirements
- R1: An active-low asynchronous reset clears `out_valid` and all histories. It sets the metric of state 0 to 0 and the metric of every other state to `INIT_PM` (default 16), so decoding starts from the all-zero encoder state.
- R2: The encoder produces three bits per input bit u. `sym[2]` = u ^ u(n-2), and `sym[1]` = `sym[0]` = u ^ u(n-1) ^ u(n-2). Starting from the zero state, input 1011010 yields the symbols 111, 011, 000, 100, 100, 000, 011.
- R3: A state is numbered {u(n-1), u(n-2)}, with u(n-1) as bit 1. The predecessors of state s are 2·s[0] and 2·s[0]+1, and the branch input bit is s[1]. The branch metric is the Hamming distance (0..3) between the received symbol and the branch's expected symbol. The survivor is the predecessor with the smaller sum, and on equal sums the lower-numbered predecessor wins.
- R4: On every accepted symbol the smallest new metric is subtracted from all new metrics. After that at least one stored metric is zero, and every metric stays below 2^(PM_W-1).
- R5: Each state's history becomes its chosen predecessor's history shifted by one, with that state's input bit added as the newest bit. The decoded bit is the oldest bit of the history of the state with the smallest new metric, taking the lowest state number on a tie. This equals tracing back `DEPTH`-1 decisions from that state.
- R6: `out_valid` first rises in the cycle after the `DEPTH`-th accepted symbol. From then on it is high for exactly the cycle after each accepted symbol. The bit for the i-th accepted symbol comes out after the (i+`DEPTH`-1)-th accepted symbol.
- R7: While `in_valid` is low the metrics and histories do not change, and `out_valid` is low in the following cycle.
- R8: An error-free encoded stream decodes to the original bits, including the directed sequence 1011010.
- R9: A stream with at most one flipped bit in every window of 10 symbols still decodes to the original bits.
- R10: The control machine leaves `ST_FILL` for `ST_RUN` on the edge that accepts the `DEPTH`-th symbol, and stays in `ST_RUN` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A received symbol is present this cycle |
| in_sym | input | 3 | Received symbol; bit 2 is the first generator's bit |
| out_valid | output | 1 | `out_bit` holds a decoded bit this cycle |
| out_bit | output | 1 | Decoded bit, oldest first |

## Verification
On every cycle the assertions check metric normalisation and its bound. They also check that metrics are frozen during stalls, that no output appears before the histories are full or without an accepted symbol, and that one appears for every accepted symbol after that. Whether the decoded bits are correct can only be shown by the bench's scenarios. These compare every output bit against an independent trace-back model, which covers tie-breaking on heavily corrupted input. They also compare against the transmitted bits for clean streams and for sparse single-bit errors, with stalls mixed in, plus a reset in mid-stream.

// File: rtl/rexvit_pkg.sv
package rexvit_pkg;
    localparam int CONS_LEN = 3;
    localparam int NSTATE   = 1 << (CONS_LEN - 1);
    localparam int SYM_W    = 3;
    localparam int BM_W     = 2;

    // state bit 1 = most recent input, bit 0 = the one before
    typedef logic [CONS_LEN-2:0] state_t;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } phase_e;

    // expected symbol for input u leaving state s (generators 5,7,7 octal)
    function automatic logic [SYM_W-1:0] branch_sym(input logic u, input state_t s);
        logic g0;
        logic g12;
        g0  = u ^ s[0];
        g12 = u ^ s[1] ^ s[0];
        return {g0, g12, g12};
    endfunction

    function automatic logic [BM_W-1:0] hamming3(input logic [SYM_W-1:0] a,
                                                 input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] d;
        d = a ^ b;
        return {1'b0, d[0]} + {1'b0, d[1]} + {1'b0, d[2]};
    endfunction
endpackage

// File: rtl/rexvit_encoder.sv
module rexvit_encoder
    import rexvit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_in,
    output logic [SYM_W-1:0] sym
);
    state_t hist;

    assign sym = branch_sym(bit_in, hist);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (en) begin
            hist <= {bit_in, hist[1]};
        end
    end
endmodule

// File: rtl/rexvit_bmu.sv
module rexvit_bmu
    import rexvit_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output logic [BM_W-1:0]  bm [NSTATE][2]
);
    for (genvar ns = 0; ns < NSTATE; ns++) begin : g_state
        for (genvar x = 0; x < 2; x++) begin : g_branch
            localparam int     PRED_I = (ns % 2) * 2 + x;
            localparam int     U_I    = ns / 2;
            localparam state_t PRED   = state_t'(PRED_I);
            assign bm[ns][x] = hamming3(sym, branch_sym(1'(U_I), PRED));
        end
    end
endmodule

// File: rtl/rexvit_acs.sv
module rexvit_acs
    import rexvit_pkg::*;
#(
    parameter int PM_W = 6
) (
    input  logic [PM_W-1:0]   pm   [NSTATE],
    input  logic [BM_W-1:0]   bm   [NSTATE][2],
    output logic [PM_W-1:0]   cand [NSTATE],
    output logic [NSTATE-1:0] dec,
    output logic [PM_W-1:0]   min_pm,
    output state_t            best
);
    for (genvar ns = 0; ns < NSTATE; ns++) begin : g_acs
        localparam int PA = (ns % 2) * 2;
        localparam int PB = PA + 1;
        logic [PM_W-1:0] sum_a;
        logic [PM_W-1:0] sum_b;
        assign sum_a    = pm[PA] + PM_W'(bm[ns][0]);
        assign sum_b    = pm[PB] + PM_W'(bm[ns][1]);
        assign dec[ns]  = (sum_b < sum_a);
        assign cand[ns] = dec[ns] ? sum_b : sum_a;
    end

    always_comb begin
        min_pm = cand[0];
        best   = '0;
        for (int i = 1; i < NSTATE; i++) begin
            if (cand[i] < min_pm) begin
                min_pm = cand[i];
                best   = state_t'(i);
            end
        end
    end
endmodule

// File: rtl/rexvit_survivor.sv
module rexvit_survivor
    import rexvit_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [NSTATE-1:0] dec,
    output logic [NSTATE-1:0] oldest
);
    localparam int HIST_W = DEPTH - 1;

    logic [HIST_W-1:0] path     [NSTATE];
    logic [HIST_W-1:0] path_nxt [NSTATE];

    for (genvar ns = 0; ns < NSTATE; ns++) begin : g_row
        localparam int PA  = (ns % 2) * 2;
        localparam int U_I = ns / 2;
        logic [HIST_W-1:0] src;
        assign src          = dec[ns] ? path[PA+1] : path[PA];
        assign path_nxt[ns] = {src[HIST_W-2:0], 1'(U_I)};
        assign oldest[ns]   = src[HIST_W-1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                path[ns] <= '0;
            end else if (en) begin
                path[ns] <= path_nxt[ns];
            end
        end
    end
endmodule

// File: rtl/rexvit_ctrl.sv
module rexvit_ctrl
    import rexvit_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic bit_sel,
    output logic out_valid,
    output logic out_bit
);
    localparam int CNT_W = $clog2(DEPTH);

    phase_e           phase;
    phase_e           phase_nxt;
    logic [CNT_W-1:0] fill_cnt;
    logic             last_fill;

    assign last_fill = (fill_cnt == CNT_W'(DEPTH - 1));

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            ST_FILL: if (in_valid && last_fill) phase_nxt = ST_RUN;
            ST_RUN:  phase_nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            phase <= phase_nxt;
            if (phase == ST_FILL && in_valid && !last_fill) begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= in_valid && (phase == ST_RUN || last_fill);
            if (in_valid) begin
                out_bit <= bit_sel;
            end
        end
    end
endmodule

// File: rtl/rexvit_decoder.sv
module rexvit_decoder
    import rexvit_pkg::*;
#(
    parameter int DEPTH   = 15,
    parameter int PM_W    = 6,
    parameter int INIT_PM = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_sym,
    output logic             out_valid,
    output logic             out_bit
);
    logic [BM_W-1:0]   bm   [NSTATE][2];
    logic [PM_W-1:0]   pm   [NSTATE];
    logic [PM_W-1:0]   cand [NSTATE];
    logic [NSTATE-1:0] dec;
    logic [PM_W-1:0]   min_pm;
    state_t            best;
    logic [NSTATE-1:0] oldest;

    rexvit_bmu u_bmu (
        .sym (in_sym),
        .bm  (bm)
    );

    rexvit_acs #(.PM_W(PM_W)) u_acs (
        .pm     (pm),
        .bm     (bm),
        .cand   (cand),
        .dec    (dec),
        .min_pm (min_pm),
        .best   (best)
    );

    for (genvar i = 0; i < NSTATE; i++) begin : g_pm
        localparam logic [PM_W-1:0] RST_V = (i == 0) ? PM_W'(0) : PM_W'(INIT_PM);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pm[i] <= RST_V;
            end else if (in_valid) begin
                pm[i] <= cand[i] - min_pm;
            end
        end
    end

    rexvit_survivor #(.DEPTH(DEPTH)) u_surv (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (in_valid),
        .dec    (dec),
        .oldest (oldest)
    );

    rexvit_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .bit_sel   (oldest[best]),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );
endmodule

// File: rtl/rexvit_checker.sv
module rexvit_checker
    import rexvit_pkg::*;
#(
    parameter int DEPTH = 15,
    parameter int PM_W  = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic [PM_W-1:0] pm [NSTATE]
);
    logic [NSTATE*PM_W-1:0] pm_vec;
    logic                   any_zero;
    logic                   all_low;
    int unsigned            seen;

    always_comb begin
        any_zero = 1'b0;
        all_low  = 1'b1;
        for (int i = 0; i < NSTATE; i++) begin
            pm_vec[i*PM_W +: PM_W] = pm[i];
            if (pm[i] == '0) any_zero = 1'b1;
            if (pm[i][PM_W-1]) all_low = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 0;
        end else if (in_valid && seen < DEPTH) begin
            seen <= seen + 1;
        end
    end

    AST_PM_HAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        any_zero); // R4
    AST_PM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        all_low); // R4
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(pm_vec)); // R7
    AST_OUT_NEEDS_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R7
    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen >= DEPTH); // R6
    AST_OUT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seen >= DEPTH - 1) |=> out_valid); // R10
endmodule

bind rexvit_decoder rexvit_checker #(.DEPTH(DEPTH), .PM_W(PM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .pm        (pm)
);

// File: tb/rexvit_decoder_tb.sv
module rexvit_decoder_tb;
    localparam int D    = 15;
    localparam int INIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_sym = '0;
    logic       out_valid;
    logic       out_bit;
    logic       enc_en = 1'b0;
    logic       enc_bit = 1'b0;
    logic [2:0] enc_sym;

    always #4 clk = ~clk;

    rexvit_decoder #(.DEPTH(D), .PM_W(6), .INIT_PM(INIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
        .out_valid(out_valid), .out_bit(out_bit)
    );

    rexvit_encoder u_enc (
        .clk(clk), .rst_n(rst_n), .en(enc_en), .bit_in(enc_bit), .sym(enc_sym)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bench encoder state: p1 = previous input, p2 = the one before
    bit bp1 = 0;
    bit bp2 = 0;
    int lit_exp = -1;

    function automatic logic [2:0] code_of(bit u, bit p1, bit p2);
        return {u ^ p2, u ^ p1 ^ p2, u ^ p1 ^ p2};
    endfunction

    // independent trace-back reference
    int rpm [4];
    bit rdec [4096][4];
    int rn = 0;
    int exp_q [$];
    int orig_q [$];

    function automatic int hd(logic [2:0] a, logic [2:0] b);
        return $countones(a ^ b);
    endfunction

    task automatic ref_clear();
        rpm[0] = 0;
        for (int i = 1; i < 4; i++) rpm[i] = INIT;
        rn = 0;
        exp_q.delete();
        orig_q.delete();
        bp1 = 0;
        bp2 = 0;
    endtask

    task automatic ref_step(logic [2:0] r);
        int np [4];
        int best;
        int s;
        for (int ns = 0; ns < 4; ns++) begin
            int pa = (ns % 2) * 2;
            int pb = pa + 1;
            bit u = bit'(ns / 2);
            int ma = rpm[pa] + hd(r, code_of(u, bit'(pa / 2), bit'(pa % 2)));
            int mb = rpm[pb] + hd(r, code_of(u, bit'(pb / 2), bit'(pb % 2)));
            rdec[rn][ns] = (mb < ma);
            np[ns] = (mb < ma) ? mb : ma;
        end
        best = 0;
        for (int ns = 1; ns < 4; ns++) if (np[ns] < np[best]) best = ns;
        for (int ns = 0; ns < 4; ns++) rpm[ns] = np[ns];
        if (rn >= D - 1) begin
            s = best;
            for (int k = rn; k > rn - D + 1; k--) s = (s % 2) * 2 + int'(rdec[k][s]);
            exp_q.push_back(s / 2);
        end
        rn++;
    endtask

    // kind: 0 = no original check, 1 = clean stream (R8), 2 = sparse errors (R9)
    task automatic send(bit u, logic [2:0] flip, int kind);
        logic [2:0] sym;
        @(negedge clk);
        enc_en  = 1'b1;
        enc_bit = u;
        #1;
        sym = enc_sym;
        chk(sym === code_of(u, bp1, bp2), "R2 encoder vs bench code", sym, code_of(u, bp1, bp2));
        if (lit_exp >= 0) chk(sym === 3'(lit_exp), "R2 directed symbol", sym, lit_exp);
        bp2 = bp1;
        bp1 = u;
        in_valid = 1'b1;
        in_sym   = sym ^ flip;
        ref_step(sym ^ flip);
        orig_q.push_back(kind == 0 ? -1 : (kind - 1) * 2 + int'(u));
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            enc_en   = 1'b0;
            in_valid = 1'b0;
            in_sym   = $urandom_range(0, 7);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        enc_en   = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
        ref_clear();
        rst_n = 1'b1;
    endtask

    // output monitor
    bit vin_e = 0;
    int acc = 0;
    always @(posedge clk) begin
        vin_e <= rst_n && in_valid;
        if (!rst_n) acc <= 0;
        else if (in_valid) acc <= acc + 1;
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_ov;
            exp_ov = vin_e && (acc >= D);
            if (vin_e && acc == D)
                chk(out_valid === exp_ov, "R10 R6 first output", out_valid, exp_ov);
            else if (vin_e)
                chk(out_valid === exp_ov, "R6 out_valid", out_valid, exp_ov);
            else
                chk(out_valid === 1'b0, "R7 out_valid after stall", out_valid, 0);
            if (out_valid) begin
                int e;
                int o;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                o = (orig_q.size() > 0) ? orig_q.pop_front() : -1;
                chk(int'(out_bit) == e, "R3 R5 R4 vs trace-back model", out_bit, e);
                if (o >= 0) begin
                    if (o < 2) chk(int'(out_bit) == o, "R8 clean decode", out_bit, o);
                    else       chk(int'(out_bit) == o - 2, "R9 corrected decode", out_bit, o - 2);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R6 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int lit [7];
        bit dir [7];
        int pos;
        logic [2:0] fm;
        void'($urandom(32'h5eed));
        lit = '{7, 3, 0, 4, 4, 0, 3};
        dir = '{1, 0, 1, 1, 0, 1, 0};
        ref_clear();
        repeat (2) @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid at reset", out_valid, 0);
        rst_n = 1'b1;

        // directed sequence from the zero state, then zero flush
        for (int i = 0; i < 7; i++) begin
            lit_exp = lit[i];
            send(dir[i], 3'b000, 1);
        end
        lit_exp = -1;
        for (int i = 0; i < D - 1; i++) send(1'b0, 3'b000, 1);
        idle(2);

        // clean random stream with occasional stalls
        for (int i = 0; i < 300; i++) begin
            send(bit'($urandom_range(0, 1)), 3'b000, 1);
            if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
        end
        idle(2);

        // one flipped bit per 10-symbol window
        pos = 0;
        for (int i = 0; i < 400; i++) begin
            if (i % 10 == 0) pos = $urandom_range(0, 9);
            fm = (i % 10 == pos) ? 3'(1 << $urandom_range(0, 2)) : 3'b000;
            send(bit'($urandom_range(0, 1)), fm, 2);
            if ($urandom_range(0, 5) == 0) idle($urandom_range(1, 2));
        end
        idle(2);

        // heavy noise: arbitrary symbols, ties exercised, model only
        for (int i = 0; i < 250; i++) send(bit'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 0);
        idle(1);

        // reset mid-stream, then directed sequence again
        send(1'b1, 3'b000, 0);
        do_reset();
        for (int i = 0; i < 7; i++) begin
            lit_exp = lit[i];
            send(dir[i], 3'b000, 1);
        end
        lit_exp = -1;
        for (int i = 0; i < D - 1; i++) send(1'b0, 3'b000, 1);
        idle(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule